// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It holds two component predictors. The first is a global one: a table of 3-bit saturating counters, indexed by the global outcome history XORed with PC bits. The second is a local one with two levels: a first table holds a short outcome history for each branch slot, and that history, joined with a few more PC bits, indexes a second table of 3-bit counters. A third table of 2-bit counters, indexed by PC, chooses which component supplies the final prediction.

A lookup presents a PC. One cycle later the block returns the final prediction and both component predictions. The pipeline keeps the component predictions with the branch. When the branch resolves, the pipeline sends an update with the PC, the real outcome and those saved component predictions. The update trains all three tables and shifts the global history and the branch's local history. Histories change only at resolution. The block has no speculative history and no recovery.

All table sizes are parameters. The defaults are small so that elaboration stays light. The full-size arrangement uses a 16-bit chooser index, a 16-bit global history and global index, 8 PC bits into the first local level, 11 history bits, and 4 further PC bits into the second local level.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every 3-bit counter holds 3, every chooser counter holds 1, and every history is zero. The first lookup of any PC therefore returns 0 for the final, global and local predictions, and `pred_valid` is 0 until a lookup is made.
- R2: `pred_valid` is 1 in exactly the cycle after an edge with `lu_valid` high, and 0 otherwise. The prediction outputs keep the result of the lookup at that edge.
- R3: A 3-bit counter predicts taken when its value is 4 or more. It counts up on a taken update and down on a not-taken update, and holds at 7 and at 0.
- R4: The global table index is the global history XOR PC[ALIGN+GH_W-1:ALIGN]. It uses the history as it stands at lookup time, and again at update time.
- R5: The first local level is indexed by PC[ALIGN+L1_W-1:ALIGN]. Each entry holds an LH_W-bit history of that slot's outcomes.
- R6: The second local level index is {local history, PC[ALIGN+L1_W+L2P_W-1:ALIGN+L1_W]}, with the history in the upper bits.
- R7: The chooser is indexed by PC[ALIGN+CH_W-1:ALIGN]. A counter value of 2 or more selects the global prediction, and a lower value selects the local one. On update, the chooser counts up when only the saved global prediction matched the outcome, counts down when only the saved local one matched, and holds when both matched or neither did.
- R8: On each update, the global history and the addressed local history shift left by one bit, and the actual outcome enters at bit 0.
- R9: A lookup and an update in the same cycle are not bypassed. The lookup sees the tables and histories as they were before that update.
- R10: While `up_valid` is 0, the values on the other update inputs change no table and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | Lookup request |
| lu_pc | input | PC_W | Branch PC to predict |
| pred_valid | output | 1 | Prediction outputs carry a fresh result |
| pred_taken | output | 1 | Final prediction |
| pred_global | output | 1 | Global component prediction |
| pred_local | output | 1 | Local component prediction |
| up_valid | input | 1 | Resolution update request |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_global | input | 1 | Saved global prediction for this branch |
| up_local | input | 1 | Saved local prediction for this branch |

## Verification
Every prediction is due one cycle after the rising edge that accepts its lookup. An update changes state at its own edge, so it can only affect lookups accepted at later edges. The bench tags each expected item with the cycle in which it is due and samples on the falling edge. When the due cycle comes, the bench compares all four outputs. In every other cycle it requires `pred_valid` to be low. The bench computes the expected result from its own tables before it applies the update of the same step, which makes the same-cycle case follow R9.

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int CH_W  = 8,
  parameter int GH_W  = 8,
  parameter int L1_W  = 4,
  parameter int LH_W  = 6,
  parameter int L2P_W = 2,
  parameter int CTR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lu_valid,
  input  logic [PC_W-1:0] lu_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_global,
  input  logic            up_local
);
  localparam int GN   = 1 << GH_W;
  localparam int CN   = 1 << CH_W;
  localparam int L1N  = 1 << L1_W;
  localparam int L2_W = LH_W + L2P_W;
  localparam int L2N  = 1 << L2_W;
  localparam logic [CTR_W-1:0] CINIT = CTR_W'((1 << (CTR_W-1)) - 1);

  logic [CTR_W-1:0] gtab [GN];
  logic [CTR_W-1:0] ltab [L2N];
  logic [1:0]       ctab [CN];
  logic [LH_W-1:0]  lhist [L1N];
  logic [GH_W-1:0]  ghist;

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v, input logic t);
    if (t) return (&v) ? v : v + 1'b1;
    return (v == '0) ? v : v - 1'b1;
  endfunction

  wire [GH_W-1:0] lu_gi = ghist ^ lu_pc[ALIGN +: GH_W];
  wire [L1_W-1:0] lu_l1 = lu_pc[ALIGN +: L1_W];
  wire [L2_W-1:0] lu_l2 = {lhist[lu_l1], lu_pc[ALIGN+L1_W +: L2P_W]};
  wire [CH_W-1:0] lu_ci = lu_pc[ALIGN +: CH_W];

  wire [GH_W-1:0] up_gi = ghist ^ up_pc[ALIGN +: GH_W];
  wire [L1_W-1:0] up_l1 = up_pc[ALIGN +: L1_W];
  wire [L2_W-1:0] up_l2 = {lhist[up_l1], up_pc[ALIGN+L1_W +: L2P_W]};
  wire [CH_W-1:0] up_ci = up_pc[ALIGN +: CH_W];

  wire lu_g = gtab[lu_gi][CTR_W-1];
  wire lu_l = ltab[lu_l2][CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GN; i++)  gtab[i]  <= CINIT;
      for (int i = 0; i < L2N; i++) ltab[i]  <= CINIT;
      for (int i = 0; i < CN; i++)  ctab[i]  <= 2'd1;
      for (int i = 0; i < L1N; i++) lhist[i] <= '0;
      ghist       <= '0;
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_global <= 1'b0;
      pred_local  <= 1'b0;
    end else begin
      pred_valid <= lu_valid;
      if (lu_valid) begin
        pred_global <= lu_g;
        pred_local  <= lu_l;
        pred_taken  <= ctab[lu_ci][1] ? lu_g : lu_l;
      end
      if (up_valid) begin
        gtab[up_gi]  <= bump(gtab[up_gi], up_taken);
        ltab[up_l2]  <= bump(ltab[up_l2], up_taken);
        lhist[up_l1] <= {lhist[up_l1][LH_W-2:0], up_taken};
        ghist        <= {ghist[GH_W-2:0], up_taken};
        if (up_global != up_local) begin
          if (up_global == up_taken) ctab[up_ci] <= (ctab[up_ci] == 2'd3) ? 2'd3 : ctab[up_ci] + 2'd1;
          else                       ctab[up_ci] <= (ctab[up_ci] == 2'd0) ? 2'd0 : ctab[up_ci] - 2'd1;
        end
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> pred_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_valid |=> !pred_valid);
  a_r7_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_global == pred_local) |-> pred_taken == pred_global);
  a_r8_ghist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken));
  a_r8_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[GH_W-1:1] == $past(ghist[GH_W-2:0]));
  a_r10_hold_hist: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

// File: tb/test_tournament_bp.sv
module test_tournament_bp;
  logic clk = 0, rst_n = 0;
  logic lu_valid = 0, up_valid = 0, up_taken = 0, up_global = 0, up_local = 0;
  logic [31:0] lu_pc = '0, up_pc = '0;
  logic pred_valid, pred_taken, pred_global, pred_local;

  tournament_bp #(.PC_W(32), .ALIGN(2), .CH_W(8), .GH_W(8), .L1_W(4), .LH_W(6), .L2P_W(2), .CTR_W(3))
  i_tournament_bp (.clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_pc(lu_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_global(up_global), .up_local(up_local));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit [2:0] mg [256];
  bit [2:0] ml [256];
  bit [1:0] mc [256];
  bit [5:0] mlh [16];
  bit [7:0] mgh;

  typedef struct { int due; bit t, g, l; string tag; } item_t;
  item_t q[$];

  function automatic bit [7:0] gi(input bit [31:0] pc); return mgh ^ pc[9:2]; endfunction
  function automatic bit [7:0] l2(input bit [31:0] pc); return {mlh[pc[5:2]], pc[7:6]}; endfunction
  function automatic bit [2:0] sat3(input bit [2:0] v, input bit t);
    if (t) return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input bit [31:0] lpc, input bit uv, input bit [31:0] upc,
                      input bit t, input string tag, input bit ovr = 0, input bit og = 0, input bit ol = 0);
    item_t it;
    bit sg, sl;
    @(negedge clk);
    if (lv) begin
      it.due = cyc + 1; it.tag = tag;
      it.g = mg[gi(lpc)][2]; it.l = ml[l2(lpc)][2];
      it.t = mc[lpc[9:2]][1] ? it.g : it.l;
      q.push_back(it);
    end
    sg = ovr ? og : mg[gi(upc)][2];
    sl = ovr ? ol : ml[l2(upc)][2];
    lu_valid = lv; lu_pc = lpc;
    up_valid = uv; up_pc = upc; up_taken = t; up_global = sg; up_local = sl;
    if (uv) begin
      mg[gi(upc)] = sat3(mg[gi(upc)], t);
      ml[l2(upc)] = sat3(ml[l2(upc)], t);
      if (sg != sl) begin
        if (sg == t) mc[upc[9:2]] = (mc[upc[9:2]] == 2'd3) ? 2'd3 : mc[upc[9:2]] + 2'd1;
        else         mc[upc[9:2]] = (mc[upc[9:2]] == 2'd0) ? 2'd0 : mc[upc[9:2]] - 2'd1;
      end
      mlh[upc[5:2]] = {mlh[upc[5:2]][4:0], t};
      mgh = {mgh[6:0], t};
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (running) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        chk(pred_valid == 1'b1, it.tag, "pred_valid", pred_valid, 1);
        chk(pred_global == it.g, it.tag, "pred_global", pred_global, it.g);
        chk(pred_local == it.l, it.tag, "pred_local", pred_local, it.l);
        chk(pred_taken == it.t, it.tag, "pred_taken", pred_taken, it.t);
      end else begin
        chk(pred_valid == 1'b0, "R2", "idle pred_valid", pred_valid, 0);
      end
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mg[i] = 3; ml[i] = 3; mc[i] = 1; end
    for (int i = 0; i < 16; i++) mlh[i] = 0;
    mgh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(pred_valid == 1'b0, "R1", "pred_valid after reset", pred_valid, 0);
    running = 1;

    // R1: fresh tables predict not-taken everywhere
    step(1, 32'h0000_0100, 0, 0, 0, "R1");
    step(1, 32'h0000_3ffc, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R2");
    step(1, 32'h0000_0040, 0, 0, 0, "R2");

    // R3: saturate a counter up, then one not-taken keeps it at taken
    for (int k = 0; k < 12; k++) begin
      step(1, 32'h0000_0200, 0, 0, 0, "R3");
      step(0, 0, 1, 32'h0000_0200, 1, "R3");
    end
    step(0, 0, 1, 32'h0000_0200, 0, "R3");
    step(1, 32'h0000_0200, 0, 0, 0, "R3");

    // R5 R6: repeating loop pattern on one branch trains the local tables
    for (int k = 0; k < 40; k++) begin
      step(1, 32'h0000_0344, 0, 0, 0, "R6");
      step(0, 0, 1, 32'h0000_0344, (k % 4) != 3, "R5");
    end

    // R4 R8: alternating branch with another interleaved, exercising history hashing
    for (int k = 0; k < 40; k++) begin
      step(1, 32'h0000_0510, 1, 32'h0000_0510, k[0], "R4");
      step(1, 32'h0000_0a08, 1, 32'h0000_0a08, 1, "R8");
    end

    // R7: chooser moves toward the sole correct component, holds on ties
    for (int k = 0; k < 3; k++) step(0, 0, 1, 32'h0000_0700, 1, "R7", 1, 1, 0);
    step(1, 32'h0000_0700, 0, 0, 0, "R7");
    step(0, 0, 1, 32'h0000_0700, 1, "R7", 1, 1, 1);
    step(0, 0, 1, 32'h0000_0700, 0, "R7", 1, 1, 1);
    step(1, 32'h0000_0700, 0, 0, 0, "R7");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 32'h0000_0700, 0, "R7", 1, 1, 0);
    step(1, 32'h0000_0700, 0, 0, 0, "R7");

    // R9: lookup and update of the same branch in one cycle
    for (int k = 0; k < 8; k++) step(1, 32'h0000_0900, 1, 32'h0000_0900, 1, "R9");
    step(1, 32'h0000_0900, 0, 0, 0, "R9");

    // R10: update inputs toggling with up_valid low change nothing
    for (int k = 0; k < 6; k++) step(0, 0, 0, 32'h0000_0200 + 4 * k, k[0], "R10", 1, 1, 0);
    step(1, 32'h0000_0200, 0, 0, 0, "R10");
    step(1, 32'h0000_0900, 0, 0, 0, "R10");

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] a, b;
      a = {20'h0, $urandom_range(0, 1023), 2'b00};
      b = {20'h0, $urandom_range(0, 63), 2'b00};
      step($urandom_range(0, 3) != 0, a, $urandom_range(0, 2) != 0, b,
           (b[4:2] != 3'd0) ^ ($urandom_range(0, 9) == 0), "R4");
    end
    step(0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    chk(q.size() == 0, "R2", "pending predictions", q.size(), 0);
    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule